// File: doc/BRIEF.md
# 8-bit Accumulator ALU with NZVC Flags

A purely combinational arithmetic and logic unit for an 8-bit accumulator datapath. Each evaluation takes an operation code, the accumulator operand `a_i`, a second operand `b_i` and the current condition flags. It returns an 8-bit result and the updated negative, zero, overflow and carry flags. A separate double-width output always carries the unsigned product of the two operands.

The flags follow one accumulator-machine convention. Carry is a borrow on subtraction. Overflow means the signed result left the range -128..127. Rotates pass through carry. Logic operations clear overflow. Flags that an operation does not define are copied from `flags_i`. Both flag vectors use the layout [3]=N, [2]=Z, [1]=V, [0]=C. Instruction decoding, addressing and register storage belong to the surrounding core.

Opcode encoding (`op_i`, 5 bits): 0x00 add, 0x01 add with carry, 0x02 subtract, 0x03 subtract with borrow, 0x04 negate, 0x05 increment, 0x06 decrement, 0x08 AND, 0x09 OR, 0x0A XOR, 0x0B complement, 0x0C clear, 0x10 logical shift right, 0x11 arithmetic shift right, 0x12 shift left, 0x13 rotate right, 0x14 rotate left, 0x18 multiply. Single-operand operations act on `a_i`.

Top module: `alu8_nzvc`

## Requirements
- R1: For every defined opcode except multiply, flags_o[2] (Z) is 1 exactly when res_o is 0, and flags_o[3] (N) equals res_o[7].
- R2: Add (0x00) and add with carry (0x01, adding flags_i[0]) give res_o = low 8 bits of the sum, C = 1 when the unsigned sum exceeds 255, and V = 1 when the signed sum is outside -128..127.
- R3: Subtract (0x02) and subtract with borrow (0x03, also subtracting flags_i[0]) give res_o = low 8 bits of the difference, C = 1 when the unsigned difference is below 0, and V = 1 when the signed difference is outside -128..127.
- R4: Negate (0x04) gives res_o = 0 - a_i, with C = 1 unless the result is 0 and V = 1 only when a_i is 0x80.
- R5: Increment (0x05) and decrement (0x06) give a_i + 1 and a_i - 1. V = 1 only for a_i = 0x7F (increment) or 0x80 (decrement). C is copied from flags_i[0].
- R6: AND (0x08), OR (0x09) and XOR (0x0A) combine a_i with b_i bitwise. They clear V and copy C from flags_i[0].
- R7: Complement (0x0B) gives ~a_i, clears V and sets C.
- R8: Clear (0x0C) gives res_o = 0 and flags_o = 4'b0100.
- R9: Logical shift right (0x10) fills bit 7 with 0. Arithmetic shift right (0x11) keeps bit 7. Both move a_i[0] into C. Shift left (0x12) fills bit 0 with 0 and moves a_i[7] into C. V = N XOR C of the new values.
- R10: Rotate right (0x13) moves flags_i[0] into bit 7 and a_i[0] into C. Rotate left (0x14) moves flags_i[0] into bit 0 and a_i[7] into C. V = N XOR C of the new values.
- R11: prod_o equals a_i * b_i as unsigned numbers for every opcode. Multiply (0x18) gives res_o = prod_o[7:0] and flags_o = flags_i.
- R12: Any opcode not listed gives res_o = 0 and flags_o = flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| flags_i | input | 4 | Incoming N,Z,V,C |
| res_o | output | 8 | Result |
| flags_o | output | 4 | Updated N,Z,V,C |
| prod_o | output | 16 | Unsigned product a_i * b_i |

## Verification
The hardest cases to reach are the ones where the answer depends on flags_i and not only on the operands. These are the chained carry or borrow of add-with-carry and subtract-with-borrow near the 0x7F/0x80 and 0x00/0xFF edges, and the flags that must pass through unchanged. The bench runs every accumulator value against a stride of second operands that includes 0x01, 0x7F, 0x80 and 0xFF. Each pair is applied with carry both clear and set. N, Z and V in flags_i follow a pattern tied to the operands, so a flag that should pass through but is recomputed or cleared shows as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 5;
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'h00, OP_ADC = 5'h01, OP_SUB = 5'h02, OP_SBC = 5'h03,
    OP_NEG = 5'h04, OP_INC = 5'h05, OP_DEC = 5'h06,
    OP_AND = 5'h08, OP_OR  = 5'h09, OP_EOR = 5'h0A, OP_COM = 5'h0B,
    OP_CLR = 5'h0C,
    OP_LSR = 5'h10, OP_ASR = 5'h11, OP_ASL = 5'h12, OP_ROR = 5'h13,
    OP_ROL = 5'h14,
    OP_MUL = 5'h18
  } op_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_EOR, LG_COM} lg_e;
  typedef enum logic [2:0] {SH_LSR, SH_ASR, SH_ASL, SH_ROR, SH_ROL} sh_e;

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC,
      OP_AND, OP_OR, OP_EOR, OP_COM, OP_CLR,
      OP_LSR, OP_ASR, OP_ASL, OP_ROR, OP_ROL, OP_MUL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,  // carry in (add) or borrow in (sub)
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,    // carry out (add) or borrow out (sub)
  output logic         v_o
);
  logic [W-1:0] y_eff;
  logic         ci_eff;
  logic [W:0]   ext;

  always_comb begin
    y_eff  = sub_i ? ~y_i : y_i;
    ci_eff = sub_i ? ~cin_i : cin_i;
    ext    = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, ci_eff};
    sum_o  = ext[W-1:0];
    c_o    = sub_i ? ~ext[W] : ext[W];
    // same-sign operands, result sign differs
    v_o    = (x_i[W-1] == y_eff[W-1]) && (ext[W-1] != x_i[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  lg_e          sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_EOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  sh_e          sel_i,
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  logic right;
  logic fill;

  always_comb begin
    right = (sel_i == SH_LSR) || (sel_i == SH_ASR) || (sel_i == SH_ROR);
    case (sel_i)
      SH_ASR:         fill = a_i[W-1];
      SH_ROR, SH_ROL: fill = c_i;
      default:        fill = 1'b0;
    endcase
    if (right) begin
      res_o = {fill, a_i[W-1:1]};
      c_o   = a_i[0];
    end else begin
      res_o = {a_i[W-2:0], fill};
      c_o   = a_i[W-1];
    end
  end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] pp [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < W; i++) p_o = p_o + pp[i];
  end
endmodule

// File: rtl/alu8_nzvc.sv
module alu8_nzvc
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [3:0]      flags_i,
  output logic [W-1:0]    res_o,
  output logic [3:0]      flags_o,
  output logic [2*W-1:0]  prod_o
);
  localparam logic [W-1:0] ONE = W'(1);

  op_e          op;
  logic         c_in;
  logic [W-1:0] as_x, as_y, as_sum;
  logic         as_cin, as_sub, as_c, as_v;
  lg_e          lg_sel;
  logic [W-1:0] lg_res;
  sh_e          sh_sel;
  logic [W-1:0] sh_res;
  logic         sh_c;

  assign op   = op_e'(op_i);
  assign c_in = flags_i[FL_C];

  // operand steering for the shared adder
  always_comb begin
    as_x   = a_i;
    as_y   = b_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC: as_cin = c_in;
      OP_SUB: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = c_in; end
      OP_NEG: begin as_x = '0; as_y = a_i; as_sub = 1'b1; end
      OP_INC: as_y = ONE;
      OP_DEC: begin as_y = ONE; as_sub = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_EOR:  lg_sel = LG_EOR;
      default: lg_sel = LG_COM;
    endcase
    case (op)
      OP_ASR:  sh_sel = SH_ASR;
      OP_ASL:  sh_sel = SH_ASL;
      OP_ROR:  sh_sel = SH_ROR;
      OP_ROL:  sh_sel = SH_ROL;
      default: sh_sel = SH_LSR;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .c_o(as_c), .v_o(as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .sel_i(lg_sel), .a_i(a_i), .b_i(b_i), .res_o(lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .sel_i(sh_sel), .a_i(a_i), .c_i(c_in), .res_o(sh_res), .c_o(sh_c)
  );

  alu8_mul #(.W(W)) u_mul (
    .a_i(a_i), .b_i(b_i), .p_o(prod_o)
  );

  logic [W-1:0] res;
  logic         v_new, c_new, upd_nz;

  always_comb begin
    res    = '0;
    v_new  = flags_i[FL_V];
    c_new  = c_in;
    upd_nz = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        res = as_sum; v_new = as_v; c_new = as_c;
      end
      OP_INC, OP_DEC: begin
        res = as_sum; v_new = as_v;
      end
      OP_AND, OP_OR, OP_EOR: begin
        res = lg_res; v_new = 1'b0;
      end
      OP_COM: begin
        res = lg_res; v_new = 1'b0; c_new = 1'b1;
      end
      OP_CLR: begin
        res = '0; v_new = 1'b0; c_new = 1'b0;
      end
      OP_LSR, OP_ASR, OP_ASL, OP_ROR, OP_ROL: begin
        res = sh_res; c_new = sh_c; v_new = sh_res[W-1] ^ sh_c;
      end
      OP_MUL: begin
        res = prod_o[W-1:0]; upd_nz = 1'b0;
      end
      default: upd_nz = 1'b0;
    endcase
    res_o = res;
    if (upd_nz) flags_o = {res[W-1], (res == '0), v_new, c_new};
    else        flags_o = flags_i;
  end
endmodule

// File: rtl/alu8_nzvc_chk.sv
module alu8_nzvc_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [3:0]      flags_i,
  input logic [W-1:0]    res_o,
  input logic [3:0]      flags_o,
  input logic [2*W-1:0]  prod_o
);
  logic known;
  logic nz_op;

  always_comb begin
    known = !$isunknown({op_i, a_i, b_i, flags_i});
    nz_op = op_defined(op_i) && (op_i != OP_MUL);
    if (known) begin
      // R1
      zero_flag_chk: assert (!nz_op || (flags_o[FL_Z] == (res_o == '0)))
        else $error("zero flag disagrees with result");
      // R1
      neg_flag_chk: assert (!nz_op || (flags_o[FL_N] == res_o[W-1]))
        else $error("negative flag disagrees with result");
      // R6
      logic_v_c_chk: assert (!(op_i inside {OP_AND, OP_OR, OP_EOR}) ||
                             (!flags_o[FL_V] && flags_o[FL_C] == flags_i[FL_C]))
        else $error("logic op flags wrong");
      // R8
      clear_chk: assert (op_i != OP_CLR || (res_o == '0 && flags_o == 4'b0100))
        else $error("clear output wrong");
      // R9
      shift_v_chk: assert (!(op_i inside {OP_LSR, OP_ASR, OP_ASL, OP_ROR, OP_ROL}) ||
                           (flags_o[FL_V] == (flags_o[FL_N] ^ flags_o[FL_C])))
        else $error("shift overflow flag wrong");
      // R11
      product_chk: assert (prod_o == ({{W{1'b0}}, a_i} * {{W{1'b0}}, b_i}))
        else $error("product wrong");
      // R12
      undef_pass_chk: assert (op_defined(op_i) || (res_o == '0 && flags_o == flags_i))
        else $error("undefined opcode not inert");
    end
  end
endmodule

bind alu8_nzvc alu8_nzvc_chk #(.W(W)) u_nzvc_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
  .res_o(res_o), .flags_o(flags_o), .prod_o(prod_o)
);

// File: tb/tb_alu8_nzvc.sv
`timescale 1ns/1ps
module tb_alu8_nzvc;
  import alu8_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  op;
  logic [7:0]  a, b;
  logic [3:0]  fin;
  logic [7:0]  res;
  logic [3:0]  fout;
  logic [15:0] prod;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  alu8_nzvc dut (
    .op_i(op), .a_i(a), .b_i(b), .flags_i(fin),
    .res_o(res), .flags_o(fout), .prod_o(prod)
  );

  function automatic int sx(input logic [7:0] x);
    return (x > 8'd127) ? int'(x) - 256 : int'(x);
  endfunction

  function automatic logic ovf(input int s);
    return (s > 127) || (s < -128);
  endfunction

  function automatic string tag(input logic [4:0] o);
    case (o)
      OP_ADD, OP_ADC: return "R2";
      OP_SUB, OP_SBC: return "R3";
      OP_NEG:         return "R4";
      OP_INC, OP_DEC: return "R5";
      OP_AND, OP_OR, OP_EOR: return "R6";
      OP_COM:         return "R7";
      OP_CLR:         return "R8";
      OP_LSR, OP_ASR, OP_ASL: return "R9";
      OP_ROR, OP_ROL: return "R10";
      OP_MUL:         return "R11";
      default:        return "R12";
    endcase
  endfunction

  task automatic model(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic [3:0] f, output logic [7:0] r, output logic [3:0] fo);
    int t, s;
    logic v, c, nz;
    c = f[0]; v = f[1]; nz = 1'b1; r = 8'h00;
    case (o)
      OP_ADD, OP_ADC: begin
        t = int'(x) + int'(y) + ((o == OP_ADC) ? int'(c) : 0);
        s = sx(x) + sx(y) + ((o == OP_ADC) ? int'(c) : 0);
        r = t[7:0]; c = t > 255; v = ovf(s);
      end
      OP_SUB, OP_SBC: begin
        t = int'(x) - int'(y) - ((o == OP_SBC) ? int'(c) : 0);
        s = sx(x) - sx(y) - ((o == OP_SBC) ? int'(c) : 0);
        r = t[7:0]; c = t < 0; v = ovf(s);
      end
      OP_NEG: begin t = -int'(x); r = t[7:0]; c = (r != 0); v = ovf(-sx(x)); end
      OP_INC: begin t = int'(x) + 1; r = t[7:0]; v = ovf(sx(x) + 1); end
      OP_DEC: begin t = int'(x) - 1; r = t[7:0]; v = ovf(sx(x) - 1); end
      OP_AND: begin r = x & y; v = 0; end
      OP_OR:  begin r = x | y; v = 0; end
      OP_EOR: begin r = x ^ y; v = 0; end
      OP_COM: begin r = 8'hFF - x; v = 0; c = 1; end
      OP_CLR: begin r = 0; v = 0; c = 0; end
      OP_LSR: begin r = x / 2; c = x[0]; v = r[7] ^ c; end
      OP_ASR: begin r = (x / 2) + (x[7] ? 8'h80 : 8'h00); c = x[0]; v = r[7] ^ c; end
      OP_ASL: begin t = int'(x) * 2; r = t[7:0]; c = x[7]; v = r[7] ^ c; end
      OP_ROR: begin r = (x / 2) + (f[0] ? 8'h80 : 8'h00); c = x[0]; v = r[7] ^ c; end
      OP_ROL: begin t = int'(x) * 2 + int'(f[0]); r = t[7:0]; c = x[7]; v = r[7] ^ c; end
      OP_MUL: begin t = int'(x) * int'(y); r = t[7:0]; nz = 0; end
      default: nz = 0;
    endcase
    fo = nz ? {r[7], (r == 0), v, c} : f;
  endtask

  task automatic apply(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic [3:0] f);
    logic [7:0] er;
    logic [3:0] ef;
    logic [15:0] ep;
    op = o; a = x; b = y; fin = f;
    #2;
    model(o, x, y, f, er, ef);
    ep = 16'(int'(x) * int'(y));
    n_chk++;
    if (op_defined(o) && o != OP_MUL && (fout[3:2] != ef[3:2])) begin
      n_bad++;
      $display("FAIL R1 op=%h a=%h b=%h NZ act=%b exp=%b", o, x, y, fout[3:2], ef[3:2]);
    end
    n_chk++;
    if (res !== er || fout !== ef) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h b=%h f=%b act=%h/%b exp=%h/%b",
               tag(o), o, x, y, f, res, fout, er, ef);
    end
    n_chk++;
    if (prod !== ep) begin
      n_bad++;
      $display("FAIL R11 op=%h a=%h b=%h prod act=%h exp=%h", o, x, y, prod, ep);
    end
    #2;
  endtask

  localparam logic [4:0] BIN_OPS [8] = '{OP_ADD, OP_ADC, OP_SUB, OP_SBC,
                                         OP_AND, OP_OR, OP_EOR, OP_MUL};
  localparam logic [4:0] UN_OPS [10] = '{OP_NEG, OP_INC, OP_DEC, OP_COM, OP_CLR,
                                         OP_LSR, OP_ASR, OP_ASL, OP_ROR, OP_ROL};

  initial begin
    op = OP_ADD; a = 0; b = 0; fin = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset-time state: add of zeros gives zero with Z set (R1, R2)
    apply(OP_ADD, 8'h00, 8'h00, 4'b0000);
    // binary operations: every a, strided b plus edge values, carry clear and set
    for (int k = 0; k < 8; k++)
      for (int ai = 0; ai < 256; ai++)
        for (int j = 0; j < 19; j++)
          for (int ci = 0; ci < 2; ci++) begin
            logic [7:0] bv;
            bv = (j < 16) ? 8'(j * 17) : (j == 16) ? 8'h7F : (j == 17) ? 8'h80 : 8'h01;
            apply(BIN_OPS[k], 8'(ai), bv, {3'(ai) ^ 3'(j) ^ {3{ci[0]}}, ci[0]});
          end
    // single-operand operations: every a, carry clear and set, all N/Z/V patterns
    for (int k = 0; k < 10; k++)
      for (int ai = 0; ai < 256; ai++)
        for (int fi = 0; fi < 16; fi++)
          apply(UN_OPS[k], 8'(ai), 8'(255 - ai), 4'(fi));
    // undefined opcodes are inert (R12)
    for (int o = 0; o < 32; o++)
      if (!op_defined(5'(o)))
        for (int ai = 0; ai < 256; ai += 15)
          for (int fi = 0; fi < 16; fi++)
            apply(5'(o), 8'(ai), 8'(ai * 3), 4'(fi));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule